// File: doc/BRIEF.md
# Selectable clock output divider

This block produces a square-wave clock output from a low-frequency timekeeping reference. A 3-bit rate code in a clock-output register picks one of six output frequencies. An enable bit gates the output, and a synchronisation bit decides when a new setting may take hold. With synchronisation on, a setting waits for the current output's next falling edge, so no shortened pulse reaches the pin. With it off, the setting acts on the following reference edge. In both modes the output stays low after a change until the new rate begins a fresh high phase.

The reference input `clk_ref` runs at 65.536 kHz, twice the fastest output rate, so that every output, the fastest included, comes from a flop with a 50% duty cycle. A single free-running 16-bit counter supplies all rates. A clock-output flag is set each time a new rate or enable setting takes effect. Software clears it through a status write port.

Top module: `clkout_divider`

## Requirements
- R1: After a synchronous reset (rst_n low at a clk_ref edge), clk_out and clk_flag are 0 and the output stays disabled and low until a register write enables it.
- R2: While the active output-enable bit (bit 7 of the clock-output register) is 0, clk_out is held low.
- R3: With enable set, rate code (bits 2:0) 0, 1, 2, 3, 4 and 5 give high and low phases of exactly 1, 4, 32, 512, 1024 and 32768 clk_ref cycles, i.e. 32768, 8192, 1024, 64, 32 and 1 Hz.
- R4: Rate codes 6 and 7 hold clk_out low even with enable set.
- R5: After a setting takes effect, clk_out stays low until the selected rate starts a new high phase, so the first high phase has full length.
- R6: With synchronisation (bit 6) set and the output running, a new code or enable value takes effect only at a falling edge of clk_out, and a high phase in progress completes at full length.
- R7: With synchronisation set, the low phase between two rates lasts at least the half-period of the faster of the two.
- R8: With synchronisation clear, clk_out is forced low at the clk_ref edge after the edge that stores the register write, and then runs at the new rate.
- R9: clk_flag is set when a write changing the enable bit or the rate code takes effect; a write that changes only other bits leaves it unchanged.
- R10: A status write with bit 6 equal to 0 clears clk_flag; a status write with bit 6 equal to 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 65.536 kHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the clock-output register |
| cfg_wdata | input | 8 | Register value: bit 7 enable, bit 6 synchronise, bits 2:0 rate code |
| stat_we | input | 1 | Write strobe for the status register |
| stat_wdata | input | 8 | Status value; bit 6 written 0 clears the flag |
| clk_out | output | 1 | Divided clock output |
| clk_flag | output | 1 | Clock-output flag |

## Verification
The hardest case to reach is a synchronised rate change or disable that arrives in the middle of a long high phase. The test has to show that the phase still runs to its full length and that the low gap that follows is not shortened. The stimulus waits until the monitor reports a rising edge of clk_out. It then waits a fixed number of reference cycles, still well inside the 512-cycle high phase, and writes the new register value. The phase lengths that follow are measured against the expected counts. The same test run with synchronisation cleared shows the output dropping at once.

// File: rtl/clkdiv_pkg.sv
// Shared constants, field positions and types for the clock output divider.
// Assumes the reference runs at twice the fastest output rate.
package clkdiv_pkg;

    localparam int REG_W     = 8;
    localparam int CODE_W    = 3;
    localparam int NUM_RATES = 6;
    localparam int OE_BIT    = 7;
    localparam int SYNC_BIT  = 6;
    localparam int FLAG_BIT  = 6;

    // Counter bit whose toggling gives the output for a rate code.
    function automatic int tap_index(input int code);
        case (code)
            0:       return 0;
            1:       return 2;
            2:       return 5;
            3:       return 9;
            4:       return 10;
            default: return 15;
        endcase
    endfunction

    localparam int CNT_W = tap_index(NUM_RATES - 1) + 1;

    typedef struct packed {
        logic              oe;
        logic [CODE_W-1:0] code;
    } rate_sel_t;

endpackage

// File: rtl/clkdiv_prescaler.sv
// Free-running binary counter shared by all output rates.
// Assumes nothing beyond a running clk_ref; wraps silently.
module clkdiv_prescaler #(
    parameter int WIDTH = clkdiv_pkg::CNT_W
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    output logic [WIDTH-1:0] cnt_nxt
);

    logic [WIDTH-1:0] cnt_q;

    assign cnt_nxt = cnt_q + 1'b1;

    // Advance the counter by one each reference cycle.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    // R3: every rate tap relies on a strictly incrementing count
    p_count_step_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/clkdiv_tap_mux.sv
// Selects the next value of the counter bit that belongs to a rate code.
// Assumes the code is stable for the cycle; flags codes with no rate.
module clkdiv_tap_mux #(
    parameter int WIDTH  = clkdiv_pkg::CNT_W,
    parameter int CODE_W = clkdiv_pkg::CODE_W,
    parameter int NUM    = clkdiv_pkg::NUM_RATES
) (
    input  logic [WIDTH-1:0]  cnt_nxt,
    input  logic [CODE_W-1:0] code,
    output logic              tap_nxt,
    output logic              tap_ok
);

    logic [NUM-1:0] hit;
    logic           unused_cnt;

    // One decoded tap per supported rate.
    for (genvar g = 0; g < NUM; g++) begin : g_tap
        assign hit[g] = (code == CODE_W'(g)) && cnt_nxt[clkdiv_pkg::tap_index(g)];
    end

    assign tap_nxt    = |hit;
    assign tap_ok     = (code < CODE_W'(NUM));
    assign unused_cnt = ^cnt_nxt;

endmodule

// File: rtl/clkdiv_sync_gate.sv
// Holds the active rate and enable, decides when a written setting takes
// over, and shapes the output so each high phase starts fresh.
// Assumes tap_nxt/tap_ok are decoded from act_code by the tap mux.
module clkdiv_sync_gate
    import clkdiv_pkg::*;
(
    input  logic              clk_ref,
    input  logic              rst_n,
    input  rate_sel_t         cfg_sel,
    input  logic              sync_en,
    input  logic              tap_nxt,
    input  logic              tap_ok,
    output logic [CODE_W-1:0] act_code,
    output logic              clk_out,
    output logic              take
);

    rate_sel_t act_q;
    logic      armed_q;
    logic      out_q;
    logic      run;
    logic      armed_d;
    logic      out_d;
    logic      pending;
    logic      fall;

    // Next output under the active setting and the switch-over decision.
    always_comb begin
        run     = act_q.oe && tap_ok;
        armed_d = run && (armed_q || !tap_nxt);
        out_d   = armed_d && tap_nxt;
        pending = (cfg_sel != act_q);
        fall    = out_q && !out_d;
        take    = pending && (!sync_en || !run || !armed_q || fall);
    end

    // Adopt the written setting or keep following the selected tap.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            act_q   <= '0;
            armed_q <= 1'b0;
            out_q   <= 1'b0;
        end else if (take) begin
            act_q   <= cfg_sel;
            armed_q <= 1'b0;
            out_q   <= 1'b0;
        end else begin
            armed_q <= armed_d;
            out_q   <= out_d;
        end
    end

    assign act_code = act_q.code;
    assign clk_out  = out_q;

    // R2 and R4: no active rate means a low output
    p_idle_low_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(act_q.oe && tap_ok) |-> !out_q);

    // R6: a running synchronised output that is low never switches
    p_sync_hold_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (sync_en && act_q.oe && tap_ok && armed_q && !out_q) |=> $stable(act_q));

endmodule

// File: rtl/clkout_divider.sv
// Top of the clock output divider: register capture, flag, and the
// counter, tap selection and switching stages.
// Assumes clk_ref at 65.536 kHz and writes synchronous to it.
module clkout_divider
    import clkdiv_pkg::*;
(
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             stat_we,
    input  logic [REG_W-1:0] stat_wdata,
    output logic             clk_out,
    output logic             clk_flag
);

    rate_sel_t         cfg_sel_q;
    logic              cfg_sync_q;
    logic              flag_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [CODE_W-1:0] act_code;
    logic              tap_nxt;
    logic              tap_ok;
    logic              take;
    logic              unused_bits;

    assign unused_bits = ^{cfg_wdata[5:CODE_W], stat_wdata[REG_W-1], stat_wdata[FLAG_BIT-1:0]};

    // Capture the written clock-output register fields.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            cfg_sel_q  <= '0;
            cfg_sync_q <= 1'b0;
        end else if (cfg_we) begin
            cfg_sel_q.oe   <= cfg_wdata[OE_BIT];
            cfg_sel_q.code <= cfg_wdata[CODE_W-1:0];
            cfg_sync_q     <= cfg_wdata[SYNC_BIT];
        end
    end

    // Set the flag on a switch-over; clear it on a zero status write.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)                              flag_q <= 1'b0;
        else if (take)                           flag_q <= 1'b1;
        else if (stat_we && !stat_wdata[FLAG_BIT]) flag_q <= 1'b0;
    end

    assign clk_flag = flag_q;

    clkdiv_prescaler #(.WIDTH(CNT_W)) u_prescaler (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .cnt_nxt (cnt_nxt)
    );

    clkdiv_tap_mux #(.WIDTH(CNT_W), .CODE_W(CODE_W), .NUM(NUM_RATES)) u_tap_mux (
        .cnt_nxt (cnt_nxt),
        .code    (act_code),
        .tap_nxt (tap_nxt),
        .tap_ok  (tap_ok)
    );

    clkdiv_sync_gate u_sync_gate (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .cfg_sel  (cfg_sel_q),
        .sync_en  (cfg_sync_q),
        .tap_nxt  (tap_nxt),
        .tap_ok   (tap_ok),
        .act_code (act_code),
        .clk_out  (clk_out),
        .take     (take)
    );

    // R9: a switch-over always raises the flag
    p_flag_set_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        take |=> clk_flag);

    // R10: a zero write to the flag bit clears it when no switch competes
    p_flag_clear_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (stat_we && !stat_wdata[FLAG_BIT] && !take) |=> !clk_flag);

endmodule

// File: tb/test_clkout_divider.sv
// Directed bench for the clock output divider: one task per scenario.
module test_clkout_divider;

    logic       clk_ref = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       stat_we = 1'b0;
    logic [7:0] stat_wdata = 8'h00;
    logic       clk_out;
    logic       clk_flag;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ncnt = 0;
    int edge_at = 0;
    int last_high = 0;
    int last_low = 0;
    int rises = 0;
    int falls = 0;
    logic prev = 1'b0;
    bit done = 1'b0;

    // Half-periods in reference cycles for codes 0..5 (R3).
    int half_tbl [6] = '{1, 4, 32, 512, 1024, 32768};

    clkout_divider i_clkout_divider (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .clk_out    (clk_out),
        .clk_flag   (clk_flag)
    );

    always #5 clk_ref = ~clk_ref;

    // Phase monitor: records lengths of completed high and low phases.
    always @(negedge clk_ref) begin
        ncnt = ncnt + 1;
        if (clk_out !== prev) begin
            if (clk_out === 1'b1) begin
                last_low = ncnt - edge_at;
                rises = rises + 1;
            end else begin
                last_high = ncnt - edge_at;
                falls = falls + 1;
            end
            edge_at = ncnt;
            prev = clk_out;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk_ref) begin
        cyc = cyc + 1;
        if (cyc > 195000 && !done) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=below 195000", cyc);
            finish_run();
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input string what, input int act, input int lim);
        total = total + 1;
        if (act < lim) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lim);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk_ref);
        cfg_wdata = v;
        cfg_we = 1'b1;
        @(negedge clk_ref);
        cfg_we = 1'b0;
    endtask

    task automatic wr_stat(input logic [7:0] v);
        @(negedge clk_ref);
        stat_wdata = v;
        stat_we = 1'b1;
        @(negedge clk_ref);
        stat_we = 1'b0;
    endtask

    task automatic wait_falls(input int k);
        int tgt;
        @(posedge clk_ref);
        tgt = falls + k;
        while (falls < tgt) @(posedge clk_ref);
    endtask

    task automatic wait_rises(input int k);
        int tgt;
        @(posedge clk_ref);
        tgt = rises + k;
        while (rises < tgt) @(posedge clk_ref);
    endtask

    task automatic hold_low(input string req, input int n);
        int hi;
        hi = 0;
        repeat (n) begin
            @(negedge clk_ref);
            if (clk_out !== 1'b0) hi = hi + 1;
        end
        check(req, "high samples in low window", hi, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk_ref);
        @(negedge clk_ref);
        check("R1", "clk_out in reset", int'(clk_out), 0);
        check("R1", "clk_flag in reset", int'(clk_flag), 0);
        rst_n = 1'b1;
        hold_low("R1", 100);
    endtask

    task automatic t_flag();
        wr_cfg(8'h80);
        @(negedge clk_ref);
        check("R9", "flag after enable", int'(clk_flag), 1);
        wr_stat(8'h40);
        @(negedge clk_ref);
        check("R10", "flag after writing one", int'(clk_flag), 1);
        wr_stat(8'h00);
        @(negedge clk_ref);
        check("R10", "flag after writing zero", int'(clk_flag), 0);
        wr_cfg(8'hC0);
        repeat (3) @(negedge clk_ref);
        check("R9", "flag after sync-only write", int'(clk_flag), 0);
    endtask

    task automatic t_disabled();
        wr_cfg(8'h00);
        repeat (2) @(negedge clk_ref);
        hold_low("R2", 300);
    endtask

    task automatic t_reserved();
        wr_cfg(8'h86);
        hold_low("R4", 300);
        wr_cfg(8'h87);
        hold_low("R4", 300);
    endtask

    task automatic t_rate(input int code);
        wr_cfg(8'h00);
        repeat (2) @(negedge clk_ref);
        wr_cfg(8'h80 | 8'(code));
        wait_falls(1);
        check("R5", $sformatf("first high, code %0d", code), last_high, half_tbl[code]);
        wait_rises(1);
        check("R3", $sformatf("low phase, code %0d", code), last_low, half_tbl[code]);
        wait_falls(1);
        check("R3", $sformatf("high phase, code %0d", code), last_high, half_tbl[code]);
    endtask

    task automatic t_sync_switch();
        wr_cfg(8'h00);
        wr_cfg(8'hC3);
        wait_rises(1);
        repeat (100) @(posedge clk_ref);
        wr_cfg(8'hC1);
        @(negedge clk_ref);
        check("R6", "still high after synced write", int'(clk_out), 1);
        wait_falls(1);
        check("R6", "high phase completes", last_high, 512);
        wait_rises(1);
        check_ge("R7", "low gap at switch", last_low, 4);
        wait_falls(1);
        check("R6", "new rate high phase", last_high, 4);
    endtask

    task automatic t_sync_disable();
        wr_cfg(8'h00);
        wr_cfg(8'hC3);
        wait_rises(1);
        repeat (50) @(posedge clk_ref);
        wr_cfg(8'h43);
        @(negedge clk_ref);
        check("R6", "still high after synced disable", int'(clk_out), 1);
        wait_falls(1);
        check("R6", "last high before disable", last_high, 512);
        hold_low("R6", 1200);
    endtask

    task automatic t_unsynced();
        wr_cfg(8'h83);
        wait_rises(1);
        repeat (10) @(posedge clk_ref);
        wr_cfg(8'h84);
        @(negedge clk_ref);
        check("R8", "low one edge after capture", int'(clk_out), 0);
        wait_rises(1);
        wait_falls(1);
        check("R8", "high phase at new rate", last_high, 1024);
    endtask

    task automatic t_slowest();
        wr_cfg(8'h00);
        wr_cfg(8'h85);
        wait_falls(1);
        check("R3", "high phase, code 5", last_high, 32768);
    endtask

    initial begin
        t_reset();
        t_flag();
        t_disabled();
        t_reserved();
        for (int c = 0; c < 5; c++) t_rate(c);
        t_sync_switch();
        t_sync_disable();
        t_unsynced();
        t_slowest();
        finish_run();
    end

endmodule